// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block turns a fast reference clock into the timing strobes that one serial channel needs. A 16-bit divisor is written one byte at a time, low half and high half through separate write strobes. In front of the divisor sits an optional fixed divide-by-4 stage. A select input chooses that stage, and the choice is captured whenever a divisor byte is written. The sample period is therefore the divisor times 1, or the divisor times 4, reference cycles. With a 14.7456 MHz reference, no prescaling and 16x oversampling, a divisor of 96 gives 9600 bit/s and a divisor of 1 gives 921.6 kbit/s.

Three outputs are produced. `sample_tick` is a one-cycle enable at the oversampling rate. `bit_tick` marks every 16th sample tick, or every 8th when the oversampling select is low. `baud_clk` is a registered square wave at the sample rate, intended for an external pin. All strobes are enables in the reference clock domain, not derived clocks. A divisor of zero stops the generator.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset the divisor is 0, the captured prescaler select is 0, and `sample_tick`, `bit_tick` and `baud_clk` are all low.
- R2: The divisor is {high byte, low byte}. A `div_hi_we` write sets bits 15:8 from `wdata`, a `div_lo_we` write sets bits 7:0, and each write leaves the other byte unchanged.
- R3: With the captured prescaler select at 0 and a divisor D > 0, `sample_tick` is high for exactly one cycle every D cycles. With D = 1 it is high in every cycle.
- R4: `presc_sel` is sampled on every divisor byte write. When the captured value is 1, the sample period is 4·D cycles and `sample_tick` is never high in two consecutive cycles.
- R5: `bit_tick` is only high together with `sample_tick`. It marks every 16th sample tick when `os16` is 1 and every 8th sample tick when `os16` is 0.
- R6: A write to either divisor byte restarts the count. The first `sample_tick` is in the T-th cycle after the write edge (T = sample period), and the sample-tick count toward `bit_tick` restarts at zero.
- R7: While the divisor is 0, neither tick is produced and `baud_clk` stays low.
- R8: Number the cycles of each sample period k = 0..T-1, with k = 0 being the cycle after the previous tick or after a reload. `baud_clk` in the cycle after cycle k is 1 exactly when k < floor(T/2).
- R9: `os16` acts without a reload. Lowering it after 7 or more sample ticks have been counted since the last `bit_tick` makes the very next sample tick a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_lo_we | input | 1 | Write strobe for divisor bits 7:0 |
| div_hi_we | input | 1 | Write strobe for divisor bits 15:8 |
| wdata | input | 8 | Divisor byte being written |
| presc_sel | input | 1 | Divide-by-4 prescaler select, captured on a divisor write |
| os16 | input | 1 | 1: 16 sample ticks per bit, 0: 8 |
| sample_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle bit-time enable |
| baud_clk | output | 1 | Registered sample-rate square wave for a pin |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor built from two 8-bit bytes, a 2-bit prescaler counter (divide-by-4), and ratios of 16 and 8. Random small divisors keep sample periods short, so the bench sees many bit-tick wraps, mode switches and reloads in the middle of a period. A directed load of 2304 drives a nonzero high byte, and divisors of 1 and 0 cover the continuous-tick and stopped ends of the range.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DIV_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int PRE_W   = 2;
    localparam int OS_FAST = 16;
    localparam int OS_SLOW = 8;
    localparam int BCNT_W  = $clog2(OS_FAST);

    typedef enum logic {
        OS_X8  = 1'b0,
        OS_X16 = 1'b1
    } os_mode_e;

    typedef struct packed {
        logic sample;
        logic bitt;
    } tick_t;

    // Index of the sample tick that closes one bit time.
    function automatic logic [BCNT_W-1:0] last_slot(os_mode_e m);
        return (m == OS_X16) ? BCNT_W'(OS_FAST - 1) : BCNT_W'(OS_SLOW - 1);
    endfunction
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
    parameter int DIV_W  = baud_pkg::DIV_W,
    parameter int BYTE_W = baud_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              presc_sel,
    output logic [DIV_W-1:0]  div_q,
    output logic              presc_q,
    output logic              reload
);
    localparam int HI_W = DIV_W - BYTE_W;

    assign reload = lo_we | hi_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            presc_q <= 1'b0;
        end else begin
            if (lo_we) div_q[BYTE_W-1:0]     <= wdata;
            if (hi_we) div_q[DIV_W-1:BYTE_W] <= wdata[HI_W-1:0];
            if (reload) presc_q <= presc_sel;
        end
    end
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int PRE_W = baud_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             sel,
    output logic [PRE_W-1:0] pre_cnt,
    output logic             pre_en
);
    always_ff @(posedge clk) begin
        if (rst || clr) pre_cnt <= '0;
        else            pre_cnt <= pre_cnt + 1'b1;
    end

    assign pre_en = sel ? (&pre_cnt) : 1'b1;
endmodule

// File: rtl/baud_sample_ctr.sv
module baud_sample_ctr #(
    parameter int DIV_W = baud_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] div,
    output logic [DIV_W-1:0] cnt,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic live;
    logic at_end;

    assign live   = (div != '0);
    assign at_end = (cnt == div - ONE);
    assign tick   = live && adv && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (live && adv) cnt <= at_end ? '0 : cnt + ONE;
    end
endmodule

// File: rtl/baud_bit_ctr.sv
module baud_bit_ctr
    import baud_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     tick,
    input  os_mode_e mode,
    output logic     bit_tick
);
    logic [BCNT_W-1:0] bcnt;
    logic              wrap;

    // >= so that a switch to the short ratio mid-bit closes the bit at once
    assign wrap     = (bcnt >= last_slot(mode));
    assign bit_tick = tick && wrap;

    always_ff @(posedge clk) begin
        if (rst || clr) bcnt <= '0;
        else if (tick)  bcnt <= wrap ? '0 : bcnt + 1'b1;
    end
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
    import baud_pkg::*;
#(
    parameter int DIV_W  = baud_pkg::DIV_W,
    parameter int BYTE_W = baud_pkg::BYTE_W,
    parameter int PRE_W  = baud_pkg::PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              div_lo_we,
    input  logic              div_hi_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              presc_sel,
    input  logic              os16,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              baud_clk
);
    localparam int PH_W = DIV_W + PRE_W;

    logic [DIV_W-1:0] div_q;
    logic             presc_q;
    logic             reload;
    logic [PRE_W-1:0] pre_cnt;
    logic             pre_en;
    logic [DIV_W-1:0] cnt;
    tick_t            ticks;
    logic [PH_W-1:0]  phase;
    logic [PH_W-1:0]  period;
    logic             baud_q;

    baud_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst(rst), .lo_we(div_lo_we), .hi_we(div_hi_we),
        .wdata(wdata), .presc_sel(presc_sel),
        .div_q(div_q), .presc_q(presc_q), .reload(reload)
    );

    baud_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .clr(reload), .sel(presc_q),
        .pre_cnt(pre_cnt), .pre_en(pre_en)
    );

    baud_sample_ctr #(.DIV_W(DIV_W)) u_smp (
        .clk(clk), .rst(rst), .clr(reload), .adv(pre_en), .div(div_q),
        .cnt(cnt), .tick(ticks.sample)
    );

    baud_bit_ctr u_bit (
        .clk(clk), .rst(rst), .clr(reload), .tick(ticks.sample),
        .mode(os_mode_e'(os16)), .bit_tick(ticks.bitt)
    );

    // Position inside the current sample period, in reference cycles.
    always_comb begin
        if (presc_q) begin
            phase  = {cnt, pre_cnt};
            period = {div_q, {PRE_W{1'b0}}};
        end else begin
            phase  = PH_W'(cnt);
            period = PH_W'(div_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) baud_q <= 1'b0;
        else     baud_q <= (div_q != '0) && (phase < (period >> 1));
    end

    assign sample_tick = ticks.sample;
    assign bit_tick    = ticks.bitt;
    assign baud_clk    = baud_q;
endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk #(
    parameter int DIV_W = baud_pkg::DIV_W
) (
    input logic             clk,
    input logic             rst,
    input logic             div_lo_we,
    input logic             div_hi_we,
    input logic             presc_sel,
    input logic             sample_tick,
    input logic             bit_tick,
    input logic             baud_clk,
    input logic [DIV_W-1:0] div_val,
    input logic             presc_val
);
    logic [4:0] since_bit;

    always_ff @(posedge clk) begin
        if (rst || div_lo_we || div_hi_we) since_bit <= '0;
        else if (bit_tick)                 since_bit <= '0;
        else if (sample_tick)              since_bit <= since_bit + 1'b1;
    end

    a_r5_bit_with_sample: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    a_r5_bit_spacing: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && since_bit >= 5'd15) |-> bit_tick);

    a_r7_no_tick_at_zero: assert property (@(posedge clk) disable iff (rst)
        (div_val == '0) |-> !sample_tick);

    a_r7_baud_low_at_zero: assert property (@(posedge clk) disable iff (rst)
        (div_val == '0) |=> !baud_clk);

    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (presc_val && sample_tick && !div_lo_we && !div_hi_we) |=> !sample_tick);

    a_r6_reload_quiet: assert property (@(posedge clk) disable iff (rst)
        ((div_lo_we || div_hi_we) && presc_sel) |=> !sample_tick);
endmodule

bind baud_rate_gen baud_rate_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .div_lo_we(div_lo_we), .div_hi_we(div_hi_we),
    .presc_sel(presc_sel), .sample_tick(sample_tick), .bit_tick(bit_tick),
    .baud_clk(baud_clk), .div_val(div_q), .presc_val(presc_q)
);

// File: tb/sim_baud_rate_gen.sv
module sim_baud_rate_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_lo_we = 1'b0;
    logic       div_hi_we = 1'b0;
    logic [7:0] wdata = '0;
    logic       presc_sel = 1'b0;
    logic       os16 = 1'b1;
    logic       sample_tick, bit_tick, baud_clk;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  cmp_on   = 1'b0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    baud_rate_gen u0 (
        .clk(clk), .rst(rst), .div_lo_we(div_lo_we), .div_hi_we(div_hi_we),
        .wdata(wdata), .presc_sel(presc_sel), .os16(os16),
        .sample_tick(sample_tick), .bit_tick(bit_tick), .baud_clk(baud_clk)
    );

    // Reference model built from the requirements, ports only.
    bit [15:0] m_div;
    bit        m_presc;
    int        m_pos;
    int        m_bcnt;
    bit        m_baud;

    function automatic int m_period();
        return int'(m_div) * (m_presc ? 4 : 1);
    endfunction

    function automatic int m_last();
        return os16 ? 15 : 7;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_div <= '0; m_presc <= 1'b0; m_pos <= 0; m_bcnt <= 0; m_baud <= 1'b0;
        end else begin
            m_baud <= (m_div != 0) && (m_pos < m_period() / 2);
            if (div_lo_we || div_hi_we) begin
                if (div_lo_we) m_div[7:0]  <= wdata;
                if (div_hi_we) m_div[15:8] <= wdata;
                m_presc <= presc_sel;
                m_pos   <= 0;
                m_bcnt  <= 0;
            end else if (m_period() != 0) begin
                if (m_pos == m_period() - 1) begin
                    m_pos  <= 0;
                    m_bcnt <= (m_bcnt >= m_last()) ? 0 : m_bcnt + 1;
                end else begin
                    m_pos <= m_pos + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R3 R4 R5 R7 R8 R9).
    always @(negedge clk) begin
        if (cmp_on) begin
            bit et, eb;
            et = (m_div != 0) && (m_pos == m_period() - 1);
            eb = et && (m_bcnt >= m_last());
            check(sample_tick == et, (m_div == 0) ? "R7 sample_tick" :
                  (m_presc ? "R4 sample_tick" : "R3 sample_tick"), sample_tick, et);
            check(bit_tick == eb, "R5/R9 bit_tick", bit_tick, eb);
            check(baud_clk == m_baud, (m_div == 0) ? "R7 baud_clk" : "R8 baud_clk",
                  baud_clk, m_baud);
        end
    end

    task automatic wr(input bit hi, input logic [7:0] b, input bit ps);
        @(posedge clk); #1;
        div_lo_we = !hi; div_hi_we = hi; wdata = b; presc_sel = ps;
        @(posedge clk); #1;
        div_lo_we = 1'b0; div_hi_we = 1'b0;
    endtask

    task automatic load(input int d, input bit ps);
        wr(1'b0, d[7:0], ps);
        wr(1'b1, d[15:8], ps);
    endtask

    // Cycles between two consecutive strobes of the chosen kind.
    task automatic gap(input bit use_bit, output int g);
        int n = 0;
        @(negedge clk);
        while (!(use_bit ? bit_tick : sample_tick)) @(negedge clk);
        @(negedge clk); n = 1;
        while (!(use_bit ? bit_tick : sample_tick)) begin
            @(negedge clk); n++;
        end
        g = n;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        int g, n;
        void'($urandom(32'd1234));
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs after reset
        check(!sample_tick && !bit_tick && !baud_clk, "R1 reset outputs",
              {sample_tick, bit_tick, baud_clk}, 0);
        cmp_on = 1'b1;
        idle(40);

        // R2 / R3: 2304 uses a nonzero high byte only
        load(2304, 1'b0);
        gap(1'b0, g);
        check(g == 2304, "R2 divisor 0x0900 sample period", g, 2304);

        // R3 / R5: divisor 96, 16x gives a 1536-cycle bit
        load(96, 1'b0); os16 = 1'b1;
        gap(1'b1, g);
        check(g == 1536, "R5 bit period 16x d96", g, 1536);
        os16 = 1'b0;
        gap(1'b1, g); gap(1'b1, g);
        check(g == 768, "R5 bit period 8x d96", g, 768);
        os16 = 1'b1;

        // R3: divisor 1, tick every cycle, bit every 16
        load(1, 1'b0);
        gap(1'b0, g);
        check(g == 1, "R3 divisor 1 continuous", g, 1);
        gap(1'b1, g);
        check(g == 16, "R5 bit period d1", g, 16);

        // R4: prescaler on
        load(5, 1'b1);
        gap(1'b0, g);
        check(g == 20, "R4 prescaled period d5", g, 20);

        // R6: latency from the write edge to the first tick
        load(7, 1'b0);
        wr(1'b0, 8'd7, 1'b1);
        n = 1; @(negedge clk);
        while (!sample_tick && n < 100) begin @(negedge clk); n++; end
        check(n == 28, "R6 first tick after reload", n, 28);

        // R7: divisor zero stops everything
        load(0, 1'b0);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sample_tick || bit_tick || baud_clk) n++;
        end
        check(n == 0, "R7 silent at divisor 0", n, 0);

        // R9: switch to 8x after 10 counted ticks closes the bit at once
        os16 = 1'b1;
        load(1, 1'b0);
        idle(10);
        os16 = 1'b0;
        @(negedge clk);
        check(bit_tick == 1'b1, "R9 early bit tick", bit_tick, 1);
        @(negedge clk);
        check(bit_tick == 1'b0, "R9 counter restarted", bit_tick, 0);

        // Random mixes against the model
        for (int s = 0; s < 40; s++) begin
            int d;
            d = ($urandom % 8 == 0) ? 0 : 1 + ($urandom % 40);
            os16 = $urandom % 2;
            load(d, $urandom % 2);
            for (int c = 0; c < 200 + ($urandom % 400); c++) begin
                @(posedge clk); #1;
                if ($urandom % 97 == 0) os16 = $urandom % 2;
                if ($urandom % 211 == 0) begin
                    div_lo_we = 1'b1; wdata = 8'(1 + $urandom % 30);
                    presc_sel = $urandom % 2;
                    @(posedge clk); #1;
                    div_lo_we = 1'b0;
                end
            end
        end

        cmp_on = 1'b0;
        summary();
    end

    initial begin
        #1_500_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule